// File: doc/BRIEF.md
# Page Protection Bit Manager

This block holds one write-protection flag per 16-byte page of a 512-byte serial memory, 32 flags in all. It sits behind a byte-level two-wire slave front end. That front end reports START and STOP conditions, each received byte, and the master's acknowledge after each transmitted byte. The block decides the acknowledge for every received byte and reports, for any page a writer asks about, whether that page may be programmed. A flag of 1 means the page is writable and a flag of 0 means it is locked. All flags come out of reset as 1.

A flag is read or changed by a two-phase command. First comes a write command and a page-aligned address. Then a repeated START, the identical write command, and a control byte. A read control byte turns the transfer around: the block then returns one byte per page, with the page's flag in the MSB, and moves to the next page on each master ACK. A set or clear control byte must be followed by all 16 bytes of the page, in ascending order. Each byte is compared against the stored contents through a synchronous memory read port. The flag changes at STOP only if every byte matched. A successful change loads the memory's address pointer with the page's top address and starts a busy window. During that window, command bytes are refused.

The memory read port is assumed to return, every cycle, the data at the address presented on the previous cycle.

Top module: `pgprot_mgr`

## Requirements
- R1: After reset, every page flag is 1, busy_o is 0, ptr_load_o is 0 and ack_valid_o is 0.
- R2: Every received byte gets exactly one ack_valid_o pulse, one cycle after byte_valid_i. The first byte after a START is ACKed only if its bits [7:4] equal DEV_ID (default 4'b1010) and busy_o is 0; otherwise it and all later bytes up to the next START or STOP are NACKed. Bit 0 of that byte selects read (1) or write (0), and bit 1 supplies address bit 8.
- R3: The control byte is decoded from bits [1:0] only, and bits [7:2] have no effect. 00 starts a flag read, 01 sets the page flag to 0 (locked), and 11 sets it to 1 (writable). 10 is NACKed and no flag changes.
- R4: The flag command is recognised only when the address byte's bits [3:0] are zero and the byte after the repeated START equals the first command byte. Otherwise the bytes follow the ordinary path and no flag changes.
- R5: After a 01 or 11 control byte, the k-th following byte (k = 0..15) is compared with the stored byte at page base + k. mem_addr_o presents that address before the byte arrives, and a matching byte is ACKed.
- R6: The first mismatching byte, and every byte after it, is NACKed, and the command is cancelled.
- R7: A flag changes only at a STOP that follows exactly 16 matching bytes. A STOP after fewer bytes leaves the flag unchanged, and no other event changes any flag.
- R8: A flag change raises ptr_load_o for one cycle, with ptr_o equal to the page's highest address (page base + 15).
- R9: A flag change holds busy_o high for exactly BUSY_CYC clock cycles. It starts in the cycle after the STOP is sampled. A command byte sampled while busy_o is high is NACKed.
- R10: During a flag read, tx_byte_o[7] is the flag of the current page and tx_byte_o[6:0] are all 1s.
- R11: During a flag read, each master ACK moves to the next page, and page 31 is followed by page 0. A master NACK ends the read, and prd_active_o falls.
- R12: page_wr_ok_o always shows the flag of the page on chk_page_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_i | input | 1 | STOP seen (one-cycle pulse) |
| byte_valid_i | input | 1 | A byte from the master is complete |
| byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| mem_addr_o | output | 9 | Memory read address for the compare |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| prd_active_o | output | 1 | Flag read in progress; the block transmits |
| tx_byte_o | output | 8 | Byte to transmit during a flag read |
| mack_valid_i | input | 1 | Master acknowledge slot complete |
| mack_i | input | 1 | 1 = master ACK, 0 = master NACK |
| chk_page_i | input | 5 | Page queried by the write path |
| page_wr_ok_o | output | 1 | Queried page is writable |
| busy_o | output | 1 | Flag programming in progress |
| ptr_load_o | output | 1 | Load the memory address pointer |
| ptr_o | output | 9 | Value for the address pointer |

## Verification
Two functions can meet in the same cycle: the end of the busy window and the evaluation of a new command byte. The bench commits a flag change and counts clock edges from the cycle in which the STOP is sampled. It delivers a command byte sampled exactly on the last busy cycle and expects a NACK. It then repeats the command on the first free cycle and expects an ACK. A second coincidence is also checked: a STOP that commits the change while page_wr_ok_o is being watched for that same page. The flag must flip on the same edge that raises ptr_load_o, not before.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_ARMED, ST_RCMD,
    ST_CTRL, ST_VERIFY, ST_PREAD, ST_PASS, ST_DROP
  } seq_st_e;

  localparam logic [1:0] CTL_READ = 2'b00;
  localparam logic [1:0] CTL_LOCK = 2'b01;
  localparam logic [1:0] CTL_FREE = 2'b11;
endpackage

// File: rtl/pgprot_bits.sv
module pgprot_bits #(
  parameter int PAGES = 32,
  localparam int PG_W = $clog2(PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [PG_W-1:0] wr_page_i,
  input  logic            wr_val_i,
  input  logic [PG_W-1:0] rd_page_i,
  output logic            rd_bit_o,
  input  logic [PG_W-1:0] chk_page_i,
  output logic            chk_bit_o
);
  logic [PAGES-1:0] flag_q;

  for (genvar g = 0; g < PAGES; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      flag_q[g] <= 1'b1;
      else if (wr_en_i && wr_page_i == PG_W'(g))        flag_q[g] <= wr_val_i;
    end
  end

  assign rd_bit_o  = flag_q[rd_page_i];
  assign chk_bit_o = flag_q[chk_page_i];
endmodule

// File: rtl/pgprot_busy.sv
module pgprot_busy #(
  parameter int CYC = 200,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CW'(CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pgprot_seq.sv
module pgprot_seq import pgprot_pkg::*; #(
  parameter int PG_W = 5,
  parameter int IDX_W = 4,
  parameter logic [3:0] DEV_ID = 4'b1010,
  localparam int AW = PG_W + IDX_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_i,
  input  logic            mack_valid_i,
  input  logic            mack_i,
  input  logic            busy_i,
  input  logic [7:0]      mem_rdata_i,
  output logic            ack_valid_o,
  output logic            ack_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            rd_active_o,
  output logic [PG_W-1:0] rd_page_o,
  output logic            commit_o,
  output logic [PG_W-1:0] commit_page_o,
  output logic            commit_val_o,
  output logic            ptr_load_o,
  output logic [AW-1:0]   ptr_o
);
  seq_st_e          st_q, st_d;
  logic [7:0]       cmd_q;
  logic [PG_W-1:0]  page_q, rd_page_q;
  logic [IDX_W:0]   cnt_q;
  logic             ok_q, free_q;
  logic             ack_valid_q, ack_q, load_q;
  logic [AW-1:0]    ptr_q;

  logic             ack_d, cmd_ld, addr_ld, vfy_init, vfy_step, rd_init, rd_step;
  logic [AW-1:0]    full_addr;
  logic             vfy_match;

  assign full_addr = AW'({cmd_q[1], byte_i});
  // sticky: once a byte fails, nothing later can match
  assign vfy_match = ok_q && !cnt_q[IDX_W] && (byte_i == mem_rdata_i);

  always_comb begin
    st_d     = st_q;
    ack_d    = 1'b0;
    cmd_ld   = 1'b0;
    addr_ld  = 1'b0;
    vfy_init = 1'b0;
    vfy_step = 1'b0;
    rd_init  = 1'b0;
    rd_step  = 1'b0;
    if (stop_i) begin
      st_d = ST_IDLE;
    end else if (start_i) begin
      st_d = (st_q == ST_ARMED) ? ST_RCMD : ST_CMD;
    end else if (byte_valid_i) begin
      unique case (st_q)
        ST_CMD, ST_RCMD: begin
          if (st_q == ST_RCMD && byte_i == cmd_q && !busy_i) begin
            ack_d = 1'b1;
            st_d  = ST_CTRL;
          end else if (byte_i[7:4] != DEV_ID || busy_i) begin
            st_d = ST_DROP;
          end else if (byte_i[0]) begin
            ack_d = 1'b1;
            st_d  = ST_PASS;
          end else begin
            ack_d  = 1'b1;
            cmd_ld = 1'b1;
            st_d   = ST_ADDR;
          end
        end
        ST_ADDR: begin
          ack_d   = 1'b1;
          addr_ld = 1'b1;
          st_d    = (full_addr[IDX_W-1:0] == '0) ? ST_ARMED : ST_PASS;
        end
        ST_ARMED, ST_PASS: begin
          ack_d = 1'b1;
          st_d  = ST_PASS;
        end
        ST_CTRL: begin
          unique case (byte_i[1:0])
            CTL_READ: begin
              ack_d   = 1'b1;
              rd_init = 1'b1;
              st_d    = ST_PREAD;
            end
            CTL_LOCK, CTL_FREE: begin
              ack_d    = 1'b1;
              vfy_init = 1'b1;
              st_d     = ST_VERIFY;
            end
            default: st_d = ST_DROP;
          endcase
        end
        ST_VERIFY: begin
          ack_d    = vfy_match;
          vfy_step = 1'b1;
        end
        default: ack_d = 1'b0;
      endcase
    end else if (st_q == ST_PREAD && mack_valid_i) begin
      if (mack_i) rd_step = 1'b1;
      else        st_d    = ST_DROP;
    end
  end

  assign commit_o = stop_i && (st_q == ST_VERIFY) && cnt_q[IDX_W] && ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cmd_q       <= '0;
      page_q      <= '0;
      rd_page_q   <= '0;
      cnt_q       <= '0;
      ok_q        <= 1'b0;
      free_q      <= 1'b0;
      ack_valid_q <= 1'b0;
      ack_q       <= 1'b0;
      load_q      <= 1'b0;
      ptr_q       <= '0;
    end else begin
      st_q        <= st_d;
      ack_valid_q <= byte_valid_i;
      ack_q       <= ack_d;
      load_q      <= commit_o;
      if (cmd_ld)  cmd_q  <= byte_i;
      if (addr_ld) page_q <= full_addr[AW-1:IDX_W];
      if (vfy_init) begin
        cnt_q  <= '0;
        ok_q   <= 1'b1;
        free_q <= byte_i[1];
      end else if (vfy_step) begin
        ok_q <= vfy_match;
        if (!cnt_q[IDX_W]) cnt_q <= cnt_q + 1'b1;
      end
      if (rd_init)      rd_page_q <= page_q;
      else if (rd_step) rd_page_q <= rd_page_q + 1'b1;
      if (commit_o)     ptr_q <= {page_q, {IDX_W{1'b1}}};
    end
  end

  assign ack_valid_o   = ack_valid_q;
  assign ack_o         = ack_q;
  assign mem_addr_o    = {page_q, cnt_q[IDX_W-1:0]};
  assign rd_active_o   = (st_q == ST_PREAD);
  assign rd_page_o     = rd_page_q;
  assign commit_page_o = page_q;
  assign commit_val_o  = free_q;
  assign ptr_load_o    = load_q;
  assign ptr_o         = ptr_q;
endmodule

// File: rtl/pgprot_mgr.sv
module pgprot_mgr #(
  parameter int PAGES = 32,
  parameter int PAGE_BYTES = 16,
  parameter int BUSY_CYC = 200,
  parameter logic [3:0] DEV_ID = 4'b1010,
  localparam int PG_W = $clog2(PAGES),
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int AW = PG_W + IDX_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_i,
  output logic            ack_valid_o,
  output logic            ack_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [7:0]      mem_rdata_i,
  output logic            prd_active_o,
  output logic [7:0]      tx_byte_o,
  input  logic            mack_valid_i,
  input  logic            mack_i,
  input  logic [PG_W-1:0] chk_page_i,
  output logic            page_wr_ok_o,
  output logic            busy_o,
  output logic            ptr_load_o,
  output logic [AW-1:0]   ptr_o
);
  logic            commit;
  logic [PG_W-1:0] commit_page, rd_page;
  logic            commit_val, rd_bit;

  pgprot_seq #(.PG_W(PG_W), .IDX_W(IDX_W), .DEV_ID(DEV_ID)) u_seq (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_valid_i, .byte_i,
    .mack_valid_i, .mack_i,
    .busy_i        (busy_o),
    .mem_rdata_i,
    .ack_valid_o, .ack_o, .mem_addr_o,
    .rd_active_o   (prd_active_o),
    .rd_page_o     (rd_page),
    .commit_o      (commit),
    .commit_page_o (commit_page),
    .commit_val_o  (commit_val),
    .ptr_load_o, .ptr_o
  );

  pgprot_bits #(.PAGES(PAGES)) u_bits (
    .clk_i, .rst_ni,
    .wr_en_i    (commit),
    .wr_page_i  (commit_page),
    .wr_val_i   (commit_val),
    .rd_page_i  (rd_page),
    .rd_bit_o   (rd_bit),
    .chk_page_i,
    .chk_bit_o  (page_wr_ok_o)
  );

  pgprot_busy #(.CYC(BUSY_CYC)) u_busy (
    .clk_i, .rst_ni,
    .load_i (commit),
    .busy_o
  );

  assign tx_byte_o = {rd_bit, 7'h7f};
endmodule

// File: rtl/pgprot_mgr_chk.sv
module pgprot_mgr_chk #(
  parameter int BUSY_CYC = 200,
  parameter int PG_W = 5,
  parameter int IDX_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  byte_valid_i,
  input logic                  ack_valid_o,
  input logic                  busy_o,
  input logic                  ptr_load_o,
  input logic [PG_W+IDX_W-1:0] ptr_o,
  input logic [PG_W-1:0]       chk_page_i,
  input logic                  page_wr_ok_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  p_ack_follows_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(byte_valid_i));

  p_flag_change_at_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(chk_page_i) && !$stable(page_wr_ok_o)) |-> ptr_load_o);

  p_ptr_page_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_o |-> (ptr_o[IDX_W-1:0] == {IDX_W{1'b1}}));

  p_commit_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_o |-> busy_o);

  p_busy_length_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 32'(BUSY_CYC)));
endmodule

bind pgprot_mgr pgprot_mgr_chk #(.BUSY_CYC(BUSY_CYC), .PG_W(PG_W), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .byte_valid_i, .ack_valid_o, .busy_o,
  .ptr_load_o, .ptr_o, .chk_page_i, .page_wr_ok_o
);

// File: tb/pgprot_mgr_test.sv
module pgprot_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 40;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start_i = 0, stop_i = 0, byte_valid_i = 0, mack_valid_i = 0, mack_i = 0;
  logic [7:0] byte_i = '0, mem_q;
  logic [4:0] chk_page_i = '0;
  logic       ack_valid_o, ack_o, prd_active_o, page_wr_ok_o, busy_o, ptr_load_o;
  logic [8:0] mem_addr_o, ptr_o;
  logic [7:0] tx_byte_o;
  logic [7:0] mem [512];
  logic       model [32];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) mem_q <= mem[mem_addr_o];

  pgprot_mgr #(.BUSY_CYC(BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .stop_i, .byte_valid_i, .byte_i,
    .ack_valid_o, .ack_o, .mem_addr_o, .mem_rdata_i(mem_q), .prd_active_o, .tx_byte_o,
    .mack_valid_i, .mack_i, .chk_page_i, .page_wr_ok_o, .busy_o, .ptr_load_o, .ptr_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask

  task automatic xbyte(input logic [7:0] b, input bit exp, input string req);
    @(negedge clk) begin byte_i = b; byte_valid_i = 1; end
    @(negedge clk) byte_valid_i = 0;
    chk(req, "ack_valid", ack_valid_o, 1);
    chk(req, "ack", ack_o, exp);
  endtask

  function automatic logic [7:0] cmd_of(input int pg);
    return 8'hA0 | 8'((pg >> 4) << 1);
  endfunction

  function automatic logic [7:0] addr_of(input int pg);
    return 8'((pg & 15) << 4);
  endfunction

  // bad < 0: all bytes match; hold = 0 returns right after the STOP
  task automatic prot_op(input int pg, input logic [7:0] ctl, input int bad, input int nb, input bit hold);
    bit ok = 1;
    bit commit;
    do_start();
    xbyte(cmd_of(pg), 1, "R2");
    xbyte(addr_of(pg), 1, "R2");
    do_start();
    xbyte(cmd_of(pg), 1, "R4");
    xbyte(ctl, 1, "R3");
    for (int i = 0; i < nb; i++) begin
      bit e;
      chk("R5", "mem_addr", 32'(mem_addr_o), 32'(pg * 16 + i));
      e = ok && (i != bad);
      xbyte(mem[pg * 16 + i] ^ ((i == bad) ? 8'h01 : 8'h00), e, "R6");
      if (!e) ok = 0;
    end
    commit = ok && (nb == 16);
    chk_page_i = 5'(pg);
    do_stop();
    chk("R8", "ptr_load", ptr_load_o, commit);
    if (commit) begin
      chk("R8", "ptr", ptr_o, 32'(pg * 16 + 15));
      model[pg] = ctl[1];
    end
    chk("R9", "busy", busy_o, commit);
    chk("R7", "flag", page_wr_ok_o, model[pg]);
    if (commit && hold) repeat (BUSY + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy_o, 0);
    chk("R1", "ptr_load", ptr_load_o, 0);
    chk("R1", "ack_valid", ack_valid_o, 0);
    for (int p = 0; p < 32; p++) begin
      chk_page_i = 5'(p);
      #1 chk("R1", "flag", page_wr_ok_o, 1);
    end
  endtask

  task automatic t_bad_id();
    do_start();
    xbyte(8'hB0, 0, "R2");
    xbyte(8'h00, 0, "R2");
    do_stop();
  endtask

  task automatic t_bad_ctl();
    do_start();
    xbyte(cmd_of(9), 1, "R2");
    xbyte(addr_of(9), 1, "R2");
    do_start();
    xbyte(cmd_of(9), 1, "R4");
    xbyte(8'h02, 0, "R3");
    xbyte(mem[9 * 16], 0, "R3");
    chk_page_i = 5'd9;
    do_stop();
    chk("R3", "flag after 10", page_wr_ok_o, 1);
  endtask

  task automatic t_nonzero_addr();
    do_start();
    xbyte(cmd_of(12), 1, "R4");
    xbyte(addr_of(12) | 8'h03, 1, "R4");
    do_start();
    xbyte(cmd_of(12), 1, "R4");
    xbyte(8'h01, 1, "R4");
    for (int i = 0; i < 16; i++) xbyte(mem[12 * 16 + i], 1, "R4");
    chk_page_i = 5'd12;
    do_stop();
    chk("R4", "ptr_load", ptr_load_o, 0);
    chk("R4", "flag", page_wr_ok_o, 1);
  endtask

  task automatic t_read(input int pg, input int n);
    do_start();
    xbyte(cmd_of(pg), 1, "R2");
    xbyte(addr_of(pg), 1, "R2");
    do_start();
    xbyte(cmd_of(pg), 1, "R4");
    xbyte(8'hFC, 1, "R3");
    for (int k = 0; k < n; k++) begin
      int p = (pg + k) % 32;
      chk("R10", "tx_byte", tx_byte_o, {model[p], 7'h7f});
      chk("R11", "prd_active", prd_active_o, 1);
      @(negedge clk) begin mack_valid_i = 1; mack_i = (k != n - 1); end
      @(negedge clk) mack_valid_i = 0;
    end
    chk("R11", "prd_active after nack", prd_active_o, 0);
    do_stop();
  endtask

  task automatic t_busy_edge();
    prot_op(20, 8'hFD, -1, 16, 0);  // now at the negedge after the STOP edge E0
    do_start();
    repeat (BUSY - 4) @(negedge clk);
    chk("R9", "busy last cycle", busy_o, 1);
    xbyte(cmd_of(20), 0, "R9");      // sampled at E0+BUSY
    chk("R9", "busy released", busy_o, 0);
    do_start();
    xbyte(cmd_of(20), 1, "R9");
    do_stop();
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 32; p++) begin
      chk_page_i = 5'(p);
      #1 chk("R12", "flag sweep", page_wr_ok_o, model[p]);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    for (int p = 0; p < 32; p++) model[p] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bad_id();
    prot_op(3, 8'h01, -1, 16, 1);   // R3 lock
    prot_op(7, 8'h01, 5, 16, 1);    // R6 mismatch
    prot_op(7, 8'h01, -1, 10, 1);   // R7 early stop
    prot_op(3, 8'h03, -1, 16, 1);   // R3 free
    prot_op(19, 8'hED, -1, 16, 1);  // R3 upper bits ignored, A8 page
    t_bad_ctl();
    t_nonzero_addr();
    prot_op(30, 8'h01, -1, 16, 1);
    prot_op(0, 8'h01, -1, 16, 1);
    t_read(30, 4);                  // R11 wrap 31 -> 0
    t_busy_edge();
    repeat (BUSY + 4) @(negedge clk);
    t_sweep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule